// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block picks, for a single CPU target, the most urgent interrupt out of a parameterised set of sources. An interrupt can be picked only when its enable bit and its pending bit are both set. Each source carries an 8-bit priority, and a lower number is more urgent. The block then applies two separate thresholds. A per-CPU priority mask decides whether the winner is reported as pending at all. A strict comparison against the priority of the interrupt the CPU is already servicing decides whether the request line to the CPU goes high.

Acknowledge logic, completion logic and register access sit outside this block. They supply the vectors, the mask, the running priority and the two enables as plain inputs, and they read the reported ID and priority back. The reported ID takes the value 1023 whenever nothing qualifies. Its reported priority is then 0x100, which sits above every 8-bit value. The comparison is a registered tree, so every output follows its inputs one clock later.

Top module: `hp_irq_select`

## Requirements
- R1: An interrupt is a candidate only when both its bit in `irq_enable` and its bit in `irq_pending` are 1. An interrupt with only one of the two bits set is never reported.
- R2: Among the candidates, the one with the numerically smallest priority wins. When two candidates have equal priority, the one with the lower interrupt number wins.
- R3: When there is no candidate, `pend_id` is 1023 and `pend_prio` is 0x100. `pend_id` is 1023 exactly when `pend_prio` is 0x100.
- R4: The winner appears on `pend_id`/`pend_prio` only when its priority is less than or equal to `prio_mask`. Otherwise `pend_id` is 1023 and `pend_prio` is 0x100.
- R5: `irq_req` is 1 only when an ID is reported and its priority is strictly less than `run_prio`. Equal priority leaves the line low.
- R6: When `dist_en` or `cpu_if_en` is 0, `irq_req` is 0 and `pend_id` is 1023.
- R7: With `run_prio` at 0x100 (nothing running), any reported winner raises `irq_req`. This includes priority 0xFF under mask 0xFF.
- R8: Every output reflects the inputs present at the previous rising clock edge, which is a latency of exactly one clock.
- R9: While `rst_n` is low at a clock edge, the outputs after that edge are `pend_id` 1023, `pend_prio` 0x100 and `irq_req` 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dist_en | input | 1 | Global distribution enable |
| cpu_if_en | input | 1 | Enable of this CPU's interface |
| irq_enable | input | N_IRQ | Per-interrupt enable bits for this CPU |
| irq_pending | input | N_IRQ | Per-interrupt pending bits for this CPU |
| irq_prio | input | 8*N_IRQ | Priority of interrupt i in bits [8i+7:8i] |
| prio_mask | input | 8 | Highest priority value still reported |
| run_prio | input | 9 | Priority of the running interrupt, 0x100 when idle |
| pend_id | output | 10 | Reported interrupt ID, 1023 when none |
| pend_prio | output | 9 | Priority of the reported ID, 0x100 when none |
| irq_req | output | 1 | Interrupt request line to the CPU |

## Verification
The checker watches several properties on every cycle against the inputs of the previous cycle. It checks that a reported ID was a real candidate and that a reported priority never exceeds the mask. It checks that a raised line always carries a priority strictly below the running one, and that a cleared enable always yields 1023 with the line low. It also checks that an idle running priority always raises the line for any reported ID. Some behaviours can only be shown by the bench's chosen patterns, because a single cycle does not prove them. These are which candidate wins under ties and under mixed priorities, the exact boundary values of the mask and running-priority comparisons, the one-clock latency, and the state forced by reset.

// File: rtl/hpis_pkg.sv
// Shared types and constants for the highest-priority interrupt selector.
// Assumes 8-bit priorities and 10-bit interrupt IDs, with 1023 reserved
// to mean "no interrupt".
package hpis_pkg;
    localparam int PRIO_W = 8;
    localparam int RANK_W = PRIO_W + 1;
    localparam int ID_W   = 10;

    localparam logic [ID_W-1:0]   NO_IRQ_ID = 10'd1023;
    localparam logic [RANK_W-1:0] IDLE_RANK = 9'h100;

    // A candidate: widened priority (0x100 = none) and its ID.
    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [ID_W-1:0]   id;
    } cand_t;

    // The upper input replaces the lower only when strictly more urgent,
    // so ties keep the lower-numbered side.
    function automatic cand_t pick(cand_t lo, cand_t hi);
        return (hi.rank < lo.rank) ? hi : lo;
    endfunction
endpackage

// File: rtl/hpis_cand_gen.sv
// Turns the enable, pending and priority inputs into one candidate per lane.
// Lanes that are not both enabled and pending become idle entries
// (rank 0x100, ID 1023), so they can never beat a real candidate.
module hpis_cand_gen
    import hpis_pkg::*;
#(
    parameter int N_IRQ = 64
) (
    input  logic [N_IRQ-1:0]        en,
    input  logic [N_IRQ-1:0]        pd,
    input  logic [N_IRQ*PRIO_W-1:0] prio,
    output cand_t [N_IRQ-1:0]       lanes
);
    for (genvar g = 0; g < N_IRQ; g++) begin : g_lane
        // Qualify one lane by its enable and pending bits.
        always_comb begin
            if (en[g] && pd[g]) begin
                lanes[g].rank = {1'b0, prio[g*PRIO_W +: PRIO_W]};
                lanes[g].id   = ID_W'(g);
            end else begin
                lanes[g].rank = IDLE_RANK;
                lanes[g].id   = NO_IRQ_ID;
            end
        end
    end
endmodule

// File: rtl/hpis_cmp_tree.sv
// Balanced binary comparison tree that reduces the lane candidates to the
// most urgent one. The lanes are padded with idle entries up to a power of
// two. At each node the left input covers lower IDs, so on equal rank the
// left input is kept.
module hpis_cmp_tree
    import hpis_pkg::*;
#(
    parameter int N_IRQ = 64
) (
    input  cand_t [N_IRQ-1:0] lanes,
    output cand_t             best
);
    localparam int DEPTH  = (N_IRQ > 1) ? $clog2(N_IRQ) : 0;
    localparam int LEAVES = 1 << DEPTH;

    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
        localparam int W = LEAVES >> l;
        cand_t nd [W];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_in
                if (i < N_IRQ) begin : g_real
                    assign nd[i] = lanes[i];
                end else begin : g_pad
                    assign nd[i] = '{rank: IDLE_RANK, id: NO_IRQ_ID};
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_cmp
                assign nd[j] = pick(g_lvl[l-1].nd[2*j], g_lvl[l-1].nd[2*j+1]);
            end
        end
    end

    assign best = g_lvl[DEPTH].nd[0];
endmodule

// File: rtl/hpis_gate.sv
// Applies the enables and the two thresholds to the registered winner.
// The mask filters what is reported. The strict running-priority compare
// decides the request line. Purely combinational.
module hpis_gate
    import hpis_pkg::*;
(
    input  cand_t             best,
    input  logic              live,
    input  logic [PRIO_W-1:0] mask,
    input  logic [RANK_W-1:0] run,
    output logic [ID_W-1:0]   pend_id,
    output logic [RANK_W-1:0] pend_prio,
    output logic              irq_req
);
    // Report the winner if enabled and within the mask, then test it
    // against the running priority.
    always_comb begin
        pend_id   = NO_IRQ_ID;
        pend_prio = IDLE_RANK;
        irq_req   = 1'b0;
        if (live && (best.rank <= {1'b0, mask})) begin
            pend_id   = best.id;
            pend_prio = best.rank;
            irq_req   = (best.rank < run);
        end
    end
endmodule

// File: rtl/hp_irq_select.sv
// Highest-priority interrupt selector for one CPU target.
// The comparison tree result and all threshold inputs are captured in a
// single register stage, so the outputs follow the inputs one clock later.
// Assumes a synchronous active-low reset.
module hp_irq_select
    import hpis_pkg::*;
#(
    parameter int N_IRQ = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dist_en,
    input  logic                    cpu_if_en,
    input  logic [N_IRQ-1:0]        irq_enable,
    input  logic [N_IRQ-1:0]        irq_pending,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]       prio_mask,
    input  logic [RANK_W-1:0]       run_prio,
    output logic [ID_W-1:0]         pend_id,
    output logic [RANK_W-1:0]       pend_prio,
    output logic                    irq_req
);
    cand_t [N_IRQ-1:0] lanes;
    cand_t             best_d;
    cand_t             best_q;
    logic              live_q;
    logic [PRIO_W-1:0] mask_q;
    logic [RANK_W-1:0] run_q;

    hpis_cand_gen #(.N_IRQ(N_IRQ)) u_cand (
        .en    (irq_enable),
        .pd    (irq_pending),
        .prio  (irq_prio),
        .lanes (lanes)
    );

    hpis_cmp_tree #(.N_IRQ(N_IRQ)) u_tree (
        .lanes (lanes),
        .best  (best_d)
    );

    // Capture the winner and the threshold inputs on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_q <= '{rank: IDLE_RANK, id: NO_IRQ_ID};
            live_q <= 1'b0;
            mask_q <= 8'hF0;
            run_q  <= IDLE_RANK;
        end else begin
            best_q <= best_d;
            live_q <= dist_en && cpu_if_en;
            mask_q <= prio_mask;
            run_q  <= run_prio;
        end
    end

    hpis_gate u_gate (
        .best      (best_q),
        .live      (live_q),
        .mask      (mask_q),
        .run       (run_q),
        .pend_id   (pend_id),
        .pend_prio (pend_prio),
        .irq_req   (irq_req)
    );
endmodule

// File: rtl/hpis_chk.sv
// Cycle-by-cycle checker for hp_irq_select. It relates the outputs to the
// inputs seen one clock earlier. It is attached to the top by bind.
module hpis_chk
    import hpis_pkg::*;
#(
    parameter int N_IRQ = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dist_en,
    input logic                    cpu_if_en,
    input logic [N_IRQ-1:0]        irq_enable,
    input logic [N_IRQ-1:0]        irq_pending,
    input logic [PRIO_W-1:0]       prio_mask,
    input logic [RANK_W-1:0]       run_prio,
    input logic [ID_W-1:0]         pend_id,
    input logic [RANK_W-1:0]       pend_prio,
    input logic                    irq_req
);
    localparam int LW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic             armed;
    logic [N_IRQ-1:0] cand_q;

    // Note that one full cycle out of reset has passed, and record the
    // previous cycle's candidates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            cand_q <= '0;
        end else begin
            armed  <= 1'b1;
            cand_q <= irq_enable & irq_pending;
        end
    end

    // R1
    cand_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pend_id != NO_IRQ_ID) |->
            (pend_id < ID_W'(N_IRQ) && cand_q[pend_id[LW-1:0]]));

    // R3
    id_rank_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_id == NO_IRQ_ID) == (pend_prio == IDLE_RANK));

    // R4
    mask_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pend_id != NO_IRQ_ID) |-> (pend_prio <= {1'b0, $past(prio_mask)}));

    // R5
    line_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && irq_req) |-> (pend_prio < $past(run_prio)));

    // R5
    line_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_id != NO_IRQ_ID));

    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !($past(dist_en) && $past(cpu_if_en))) |->
            (!irq_req && pend_id == NO_IRQ_ID));

    // R7
    idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pend_id != NO_IRQ_ID && $past(run_prio) == IDLE_RANK) |-> irq_req);
endmodule

bind hp_irq_select hpis_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dist_en     (dist_en),
    .cpu_if_en   (cpu_if_en),
    .irq_enable  (irq_enable),
    .irq_pending (irq_pending),
    .prio_mask   (prio_mask),
    .run_prio    (run_prio),
    .pend_id     (pend_id),
    .pend_prio   (pend_prio),
    .irq_req     (irq_req)
);

// File: tb/hp_irq_select_tb.sv
// Self-checking bench: a table of vectors followed by directed tests.
module hp_irq_select_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;
    localparam logic [N-1:0] ALL = '1;

    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] pd;
        logic [7:0]   pdef;
        logic [5:0]   la;
        logic [7:0]   pa;
        logic [5:0]   lb;
        logic [7:0]   pb;
        logic [7:0]   mask;
        logic [8:0]   run;
        logic         ge;
        logic         ce;
        logic [9:0]   eid;
        logic [8:0]   eprio;
        logic         eirq;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R3: nothing pending
        '{ALL, 64'h0, 8'h80, 6'd0, 8'h80, 6'd0, 8'h80, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd1023, 9'h100, 1'b0, 4'd3},
        // R7: single lane 5, idle running priority
        '{ALL, 64'h20, 8'h80, 6'd0, 8'h80, 6'd0, 8'h80, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd5, 9'h080, 1'b1, 4'd7},
        // R1: lane 5 pending but not enabled
        '{~64'h20, 64'h20, 8'h80, 6'd0, 8'h80, 6'd0, 8'h80, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd1023, 9'h100, 1'b0, 4'd1},
        // R2: lane 40 more urgent than lane 3
        '{ALL, 64'h0000_0100_0000_0008, 8'h80, 6'd40, 8'h10, 6'd40, 8'h10, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd40, 9'h010, 1'b1, 4'd2},
        // R2: tie between lanes 10 and 20
        '{ALL, 64'h0010_0400, 8'h40, 6'd0, 8'h40, 6'd0, 8'h40, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd10, 9'h040, 1'b1, 4'd2},
        // R2: tie between lanes 62 and 63
        '{ALL, 64'hC000_0000_0000_0000, 8'h40, 6'd0, 8'h40, 6'd0, 8'h40, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd62, 9'h040, 1'b1, 4'd2},
        // R4: priority equal to mask is reported
        '{ALL, 64'h80, 8'hF0, 6'd0, 8'hF0, 6'd0, 8'hF0, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd7, 9'h0F0, 1'b1, 4'd4},
        // R4: priority just above mask is hidden
        '{ALL, 64'h80, 8'hF1, 6'd0, 8'hF1, 6'd0, 8'hF1, 8'hF0, 9'h100, 1'b1, 1'b1, 10'd1023, 9'h100, 1'b0, 4'd4},
        // R5: equal running priority keeps line low
        '{ALL, 64'h80, 8'h40, 6'd0, 8'h40, 6'd0, 8'h40, 8'hF0, 9'h040, 1'b1, 1'b1, 10'd7, 9'h040, 1'b0, 4'd5},
        // R5: running priority one above raises line
        '{ALL, 64'h80, 8'h40, 6'd0, 8'h40, 6'd0, 8'h40, 8'hF0, 9'h041, 1'b1, 1'b1, 10'd7, 9'h040, 1'b1, 4'd5},
        // R6: global enable off
        '{ALL, 64'h20, 8'h80, 6'd0, 8'h80, 6'd0, 8'h80, 8'hF0, 9'h100, 1'b0, 1'b1, 10'd1023, 9'h100, 1'b0, 4'd6},
        // R6: CPU interface enable off
        '{ALL, 64'h20, 8'h80, 6'd0, 8'h80, 6'd0, 8'h80, 8'hF0, 9'h100, 1'b1, 1'b0, 10'd1023, 9'h100, 1'b0, 4'd6},
        // R4: winner 9 (0x10) above mask 0x0F hides everything
        '{ALL, 64'h204, 8'h80, 6'd2, 8'h20, 6'd9, 8'h10, 8'h0F, 9'h100, 1'b1, 1'b1, 10'd1023, 9'h100, 1'b0, 4'd4},
        // R7: priority 0xFF under mask 0xFF on lane 63
        '{ALL, 64'h8000_0000_0000_0000, 8'hFF, 6'd0, 8'hFF, 6'd0, 8'hFF, 8'hFF, 9'h100, 1'b1, 1'b1, 10'd63, 9'h0FF, 1'b1, 4'd7},
        // R2: lane 9 (0x10) beats lane 2 (0x20)
        '{ALL, 64'h204, 8'h80, 6'd2, 8'h20, 6'd9, 8'h10, 8'hFF, 9'h100, 1'b1, 1'b1, 10'd9, 9'h010, 1'b1, 4'd2}
    };

    logic           clk;
    logic           rst_n;
    logic           dist_en;
    logic           cpu_if_en;
    logic [N-1:0]   irq_enable;
    logic [N-1:0]   irq_pending;
    logic [N*8-1:0] irq_prio;
    logic [7:0]     prio_mask;
    logic [8:0]     run_prio;
    logic [9:0]     pend_id;
    logic [8:0]     pend_prio;
    logic           irq_req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    hp_irq_select #(.N_IRQ(N)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dist_en     (dist_en),
        .cpu_if_en   (cpu_if_en),
        .irq_enable  (irq_enable),
        .irq_pending (irq_pending),
        .irq_prio    (irq_prio),
        .prio_mask   (prio_mask),
        .run_prio    (run_prio),
        .pend_id     (pend_id),
        .pend_prio   (pend_prio),
        .irq_req     (irq_req)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic check(string tag, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_out(string tag, int eid, int eprio, int eirq);
        check({tag, " id"}, int'(pend_id), eid);
        check({tag, " prio"}, int'(pend_prio), eprio);
        check({tag, " irq"}, int'(irq_req), eirq);
    endtask

    task automatic drive(vec_t v);
        irq_enable  = v.en;
        irq_pending = v.pd;
        for (int i = 0; i < N; i++) irq_prio[i*8 +: 8] = v.pdef;
        irq_prio[v.la*8 +: 8] = v.pa;
        irq_prio[v.lb*8 +: 8] = v.pb;
        prio_mask = v.mask;
        run_prio  = v.run;
        dist_en   = v.ge;
        cpu_if_en = v.ce;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(VEC[1]);
        @(negedge clk);
        @(negedge clk);
        // R9: reset state, with a candidate on the inputs
        check_out("R9 reset", 1023, 256, 0);

        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k]);
            @(negedge clk);
            check_out($sformatf("R%0d vec%0d", VEC[k].req, k),
                      int'(VEC[k].eid), int'(VEC[k].eprio), int'(VEC[k].eirq));
        end

        // R8: one-clock latency, old value held until the next rising edge
        @(negedge clk);
        drive(VEC[1]);
        @(negedge clk);
        check_out("R8 settle", 5, 128, 1);
        irq_pending = '0;
        #1;
        check_out("R8 before edge", 5, 128, 1);
        @(negedge clk);
        check_out("R8 after edge", 1023, 256, 0);

        // R9: reset during activity clears the outputs
        drive(VEC[1]);
        @(negedge clk);
        check_out("R9 active", 5, 128, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R9 mid-run reset", 1023, 256, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R9 after release", 5, 128, 1);

        finish_run();
    end
endmodule